// File: doc/BRIEF.md
# Rewindable Synchronous FIFO with Programmable Level Flags

The block is a single-clock FIFO with one write port and one read port. It keeps a word count and derives five registered level flags from it: empty, full, half-full, almost-empty and almost-full. The almost thresholds come from a small offset unit. Two default threshold sets are chosen at master reset, and either threshold can be rewritten later through a configuration port.

Three pointer operations are available. The asynchronous master reset clears everything. At that reset it also latches the timing mode and the default thresholds. A synchronous partial reset empties the FIFO but keeps the mode and the thresholds, so a running channel can be flushed without being reprogrammed. A synchronous retransmit moves only the read pointer back to location zero, so the data written since the last reset can be read again.

In standard mode a read is requested and the word appears on the output after the clock edge that accepts it. In fall-through mode the oldest stored word is always present on the output, and a read removes it.

Top module: `rewind_fifo`

## Requirements
- R1: While `rst_ni` is low, the FIFO is emptied. The bench-visible flags are then empty=1, aempty=1, full=0, half=0, afull=0. `fwft_sel_i` is latched as the timing mode (1 = fall-through). `off_big_i` is latched to set both thresholds to OFF_LARGE (1) or OFF_SMALL (0). Neither latched value changes until the next master reset.
- R2: In standard mode, a read is accepted when the FIFO is not empty. The accepted word appears on `rd_data_o` after that clock edge. Words come out in the order they were written.
- R3: A write is ignored while the FIFO is full, and a read is ignored while it is empty. An accepted read together with an accepted write leaves the count unchanged. When the FIFO is full and both are requested, only the read is accepted. When it is empty and both are requested, only the write is accepted.
- R4: In fall-through mode, `rd_data_o` shows the oldest stored word from the edge after it is written, with no read request. A read removes that word and presents the next one.
- R5: `empty_o` and `full_o` are registered. They change at the same clock edge as the count they describe: empty means count 0, full means count DEPTH.
- R6: `half_o` is high exactly when the count exceeds DEPTH/2.
- R7: `aempty_o` is high when count <= almost-empty threshold. `afull_o` is high when DEPTH - count <= almost-full threshold.
- R8: When `cfg_we_i` is high, `cfg_data_i` is written into the almost-empty threshold if `cfg_sel_i`=0, or into the almost-full threshold if `cfg_sel_i`=1. The flags use the new value from that same edge onward.
- R9: When `prst_i` is high, the FIFO is emptied at the next edge. This overrides all other requests. The timing mode and both thresholds are kept.
- R10: When `rexmit_i` is high and `prst_i` is low, the read pointer returns to location zero. The count becomes the number of words written since the last reset, which must be no more than DEPTH. Any write or read requested in that cycle is ignored. Later reads replay the data from the first word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for both ports |
| rst_ni | input | 1 | Asynchronous active-low master reset |
| fwft_sel_i | input | 1 | Timing mode, latched at master reset (1 = fall-through) |
| off_big_i | input | 1 | Default threshold select, latched at master reset |
| prst_i | input | 1 | Synchronous partial reset |
| rexmit_i | input | 1 | Synchronous retransmit request |
| wr_en_i | input | 1 | Write request |
| wr_data_i | input | DW | Write data |
| rd_en_i | input | 1 | Read request |
| rd_data_o | output | DW | Read data |
| cfg_we_i | input | 1 | Threshold write strobe |
| cfg_sel_i | input | 1 | Threshold select (0 almost-empty, 1 almost-full) |
| cfg_data_i | input | AW | Threshold value |
| empty_o | output | 1 | Empty (fall-through: no word ready) |
| full_o | output | 1 | Full (fall-through: not ready for input) |
| half_o | output | 1 | More than half full |
| aempty_o | output | 1 | Programmable almost-empty |
| afull_o | output | 1 | Programmable almost-full |

## Verification
The bench goes after four kinds of boundary case.

- Filling past full and draining past empty. A design without the guards would wrap the count or overwrite the oldest word, and the flags would stop matching the reference count.
- Requesting a read and a write together at count zero, at count DEPTH and in between. A wrong priority loses a word or invents one.
- Partial reset after the thresholds have been reprogrammed. A design that also cleared the thresholds or the mode would show the almost-empty flag at the wrong level, or would move data at the wrong time.
- Retransmit with a write and a read held high in the same cycle. A wrong rewind would replay the wrong word, or would count the ignored write.

// File: rtl/rwf_pkg.sv
`timescale 1ns/1ps
package rwf_pkg;
  typedef struct packed {
    logic empty;
    logic full;
    logic half;
    logic aempty;
    logic afull;
  } flags_t;
endpackage

// File: rtl/rwf_store.sv
`timescale 1ns/1ps
module rwf_store #(
  parameter int DW    = 18,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/rwf_ptr_ctl.sv
`timescale 1ns/1ps
module rwf_ptr_ctl #(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          prst_i,
  input  logic          rexmit_i,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  output logic          wr_fire_o,
  output logic          rd_fire_o,
  output logic [AW-1:0] waddr_o,
  output logic [AW-1:0] raddr_o,
  output logic [CW-1:0] wr_ptr_o,
  output logic [CW-1:0] count_o,
  output logic [CW-1:0] count_d_o
);
  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);

  logic [CW-1:0] wr_q, rd_q, wr_d, rd_d;
  logic          hold;

  // partial reset and retransmit both block normal traffic
  assign hold      = prst_i | rexmit_i;
  assign count_o   = wr_q - rd_q;
  assign wr_fire_o = wr_en_i & ~hold & (count_o != FULL_C);
  assign rd_fire_o = rd_en_i & ~hold & (count_o != '0);

  always_comb begin
    wr_d = wr_q + CW'(wr_fire_o);
    rd_d = rd_q + CW'(rd_fire_o);
    if (rexmit_i) rd_d = '0;
    if (prst_i) begin
      wr_d = '0;
      rd_d = '0;
    end
  end

  assign count_d_o = wr_d - rd_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      wr_q <= wr_d;
      rd_q <= rd_d;
    end
  end

  assign waddr_o  = wr_q[AW-1:0];
  assign raddr_o  = rd_q[AW-1:0];
  assign wr_ptr_o = wr_q;
endmodule

// File: rtl/rwf_offsets.sv
`timescale 1ns/1ps
module rwf_offsets #(
  parameter int AW        = 6,
  parameter int OFF_SMALL = 7,
  parameter int OFF_LARGE = 15
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          off_big_i,
  input  logic          cfg_we_i,
  input  logic          cfg_sel_i,
  input  logic [AW-1:0] cfg_data_i,
  output logic [AW-1:0] ae_d_o,
  output logic [AW-1:0] af_d_o
);
  localparam int NOFF = 2;

  logic [NOFF-1:0][AW-1:0] off_q, off_d;

  always_comb begin
    for (int k = 0; k < NOFF; k++) begin
      off_d[k] = off_q[k];
      if (cfg_we_i && (cfg_sel_i == 1'(k))) off_d[k] = cfg_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NOFF; k++)
        off_q[k] <= off_big_i ? AW'(OFF_LARGE) : AW'(OFF_SMALL);
    end else begin
      off_q <= off_d;
    end
  end

  // next-state values so flags track a new threshold from the write edge
  assign ae_d_o = off_d[0];
  assign af_d_o = off_d[1];
endmodule

// File: rtl/rwf_flags.sv
`timescale 1ns/1ps
module rwf_flags
  import rwf_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] count_d_i,
  input  logic [AW-1:0] ae_i,
  input  logic [AW-1:0] af_i,
  output flags_t        flags_o
);
  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_C = CW'(DEPTH / 2);

  flags_t        nxt;
  logic [CW-1:0] room;

  always_comb begin
    room       = FULL_C - count_d_i;
    nxt.empty  = (count_d_i == '0);
    nxt.full   = (count_d_i == FULL_C);
    nxt.half   = (count_d_i > HALF_C);
    nxt.aempty = (count_d_i <= CW'(ae_i));
    nxt.afull  = (room <= CW'(af_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_o <= '{empty: 1'b1, full: 1'b0, half: 1'b0, aempty: 1'b1, afull: 1'b0};
    else         flags_o <= nxt;
  end
endmodule

// File: rtl/rewind_fifo.sv
`timescale 1ns/1ps
module rewind_fifo
  import rwf_pkg::*;
#(
  parameter int DW        = 18,
  parameter int DEPTH     = 64,
  parameter int OFF_SMALL = 7,
  parameter int OFF_LARGE = 15,
  localparam int AW       = $clog2(DEPTH),
  localparam int CW       = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fwft_sel_i,
  input  logic          off_big_i,
  input  logic          prst_i,
  input  logic          rexmit_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_en_i,
  output logic [DW-1:0] rd_data_o,
  input  logic          cfg_we_i,
  input  logic          cfg_sel_i,
  input  logic [AW-1:0] cfg_data_i,
  output logic          empty_o,
  output logic          full_o,
  output logic          half_o,
  output logic          aempty_o,
  output logic          afull_o
);
  logic          mode_q;
  logic          wr_fire, rd_fire;
  logic [AW-1:0] waddr, raddr, ae_d, af_d;
  logic [CW-1:0] wr_ptr_q, count_q, count_d;
  logic [DW-1:0] head, dout_q;
  flags_t        flags;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= fwft_sel_i;
  end

  rwf_ptr_ctl #(.DEPTH(DEPTH)) u_ptr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .prst_i   (prst_i),
    .rexmit_i (rexmit_i),
    .wr_en_i  (wr_en_i),
    .rd_en_i  (rd_en_i),
    .wr_fire_o(wr_fire),
    .rd_fire_o(rd_fire),
    .waddr_o  (waddr),
    .raddr_o  (raddr),
    .wr_ptr_o (wr_ptr_q),
    .count_o  (count_q),
    .count_d_o(count_d)
  );

  rwf_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk_i  (clk_i),
    .we_i   (wr_fire),
    .waddr_i(waddr),
    .wdata_i(wr_data_i),
    .raddr_i(raddr),
    .rdata_o(head)
  );

  rwf_offsets #(.AW(AW), .OFF_SMALL(OFF_SMALL), .OFF_LARGE(OFF_LARGE)) u_off (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .off_big_i (off_big_i),
    .cfg_we_i  (cfg_we_i),
    .cfg_sel_i (cfg_sel_i),
    .cfg_data_i(cfg_data_i),
    .ae_d_o    (ae_d),
    .af_d_o    (af_d)
  );

  rwf_flags #(.DEPTH(DEPTH)) u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .count_d_i(count_d),
    .ae_i     (ae_d),
    .af_i     (af_d),
    .flags_o  (flags)
  );

  // standard mode: registered output loaded by an accepted read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                dout_q <= '0;
    else if (rd_fire && !mode_q) dout_q <= head;
  end

  assign rd_data_o = mode_q ? head : dout_q;
  assign empty_o   = flags.empty;
  assign full_o    = flags.full;
  assign half_o    = flags.half;
  assign aempty_o  = flags.aempty;
  assign afull_o   = flags.afull;
endmodule

// File: rtl/rwf_chk.sv
`timescale 1ns/1ps
module rwf_chk #(
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          prst_i,
  input logic          rexmit_i,
  input logic          wr_en_i,
  input logic          rd_en_i,
  input logic          empty_o,
  input logic          full_o,
  input logic          mode_i,
  input logic [CW-1:0] count_i,
  input logic [CW-1:0] wr_ptr_i
);
  assert_empty_match_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o == (count_i == '0));

  assert_full_match_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o == (count_i == CW'(DEPTH)));

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && wr_en_i && !rd_en_i && !prst_i && !rexmit_i) |=> full_o);

  assert_no_underflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && rd_en_i && !wr_en_i && !prst_i && !rexmit_i) |=> empty_o);

  assert_prst_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prst_i |=> (empty_o && wr_ptr_i == '0));

  assert_rexmit_count_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rexmit_i && !prst_i) |=> (count_i == $past(wr_ptr_i)));

  assert_mode_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> $stable(mode_i));
endmodule

bind rewind_fifo rwf_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .prst_i  (prst_i),
  .rexmit_i(rexmit_i),
  .wr_en_i (wr_en_i),
  .rd_en_i (rd_en_i),
  .empty_o (empty_o),
  .full_o  (full_o),
  .mode_i  (mode_q),
  .count_i (count_q),
  .wr_ptr_i(wr_ptr_q)
);

// File: tb/rewind_fifo_tb.sv
`timescale 1ns/1ps
module rewind_fifo_tb;
  localparam int DW = 18, DEPTH = 16, AW = 4, SM = 2, LG = 5;

  logic clk_i = 1'b0;
  always #2 clk_i = ~clk_i;

  logic rst_ni = 1'b0, fwft_sel_i = 1'b0, off_big_i = 1'b0;
  logic prst_i = 1'b0, rexmit_i = 1'b0, wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic cfg_we_i = 1'b0, cfg_sel_i = 1'b0;
  logic [AW-1:0] cfg_data_i = '0;
  logic [DW-1:0] wr_data_i = '0, rd_data_o;
  logic empty_o, full_o, half_o, aempty_o, afull_o;

  rewind_fifo #(.DW(DW), .DEPTH(DEPTH), .OFF_SMALL(SM), .OFF_LARGE(LG)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .fwft_sel_i(fwft_sel_i), .off_big_i(off_big_i),
    .prst_i(prst_i), .rexmit_i(rexmit_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .rd_en_i(rd_en_i), .rd_data_o(rd_data_o), .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i),
    .cfg_data_i(cfg_data_i), .empty_o(empty_o), .full_o(full_o), .half_o(half_o),
    .aempty_o(aempty_o), .afull_o(afull_o)
  );

  int checks = 0, errors = 0;
  logic [DW-1:0] q[$], hist[$];
  int ae_m = SM, af_m = SM;
  bit fwft_m = 1'b0;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // flag vector order: empty full half aempty afull
  task automatic check_flags(string tag);
    int n = q.size();
    logic [4:0] exp_f = {n == 0, n == DEPTH, n > DEPTH / 2, n <= ae_m, (DEPTH - n) <= af_m};
    logic [4:0] act_f = {empty_o, full_o, half_o, aempty_o, afull_o};
    chk(act_f == exp_f, tag, int'(act_f), int'(exp_f));
  endtask

  task automatic step(bit wr, logic [DW-1:0] wd, bit rd, bit rx, bit pr, string tag);
    int n;
    bit popped = 1'b0;
    logic [DW-1:0] exp_pop = '0;
    @(negedge clk_i);
    wr_en_i = wr; wr_data_i = wd; rd_en_i = rd; rexmit_i = rx; prst_i = pr;
    @(posedge clk_i);
    #1;
    wr_en_i = 1'b0; rd_en_i = 1'b0; rexmit_i = 1'b0; prst_i = 1'b0;
    if (pr) begin
      q.delete(); hist.delete();
    end else if (rx) begin
      q = hist;
    end else begin
      n = q.size();
      if (rd && n > 0) begin exp_pop = q.pop_front(); popped = 1'b1; end
      if (wr && n < DEPTH) begin q.push_back(wd); hist.push_back(wd); end
    end
    check_flags({tag, " flags R5 R6 R7"});
    if (!fwft_m && popped) chk(rd_data_o == exp_pop, {tag, " R2 data"}, int'(rd_data_o), int'(exp_pop));
    if (fwft_m && q.size() > 0) chk(rd_data_o == q[0], {tag, " R4 head"}, int'(rd_data_o), int'(q[0]));
  endtask

  task automatic do_reset(bit fw, bit big);
    @(negedge clk_i);
    fwft_sel_i = fw; off_big_i = big; rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    fwft_sel_i = ~fw; off_big_i = ~big;  // must be ignored after reset (R1)
    q.delete(); hist.delete();
    fwft_m = fw; ae_m = big ? LG : SM; af_m = ae_m;
    #1 check_flags("R1 reset");
  endtask

  task automatic cfg(bit sel, int val);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_data_i = AW'(val);
    @(posedge clk_i);
    #1;
    cfg_we_i = 1'b0;
    if (sel) af_m = val; else ae_m = val;
    check_flags("R8 threshold");
  endtask

  task automatic t_fill_drain;
    do_reset(1'b0, 1'b0);
    for (int i = 0; i < DEPTH + 1; i++) step(1'b1, DW'(32'h100 + i), 1'b0, 1'b0, 1'b0, "R3 fill");
    for (int i = 0; i < DEPTH + 1; i++) step(1'b0, '0, 1'b1, 1'b0, 1'b0, "R2 drain");
  endtask

  task automatic t_simul;
    do_reset(1'b0, 1'b0);
    step(1'b1, 18'h0aa, 1'b1, 1'b0, 1'b0, "R3 rw empty");
    for (int i = 0; i < 3; i++) step(1'b1, DW'(32'h150 + i), 1'b0, 1'b0, 1'b0, "R3 load");
    for (int i = 0; i < 3; i++) step(1'b1, DW'(32'h160 + i), 1'b1, 1'b0, 1'b0, "R3 rw mid");
    while (q.size() < DEPTH) step(1'b1, DW'(32'h170 + q.size()), 1'b0, 1'b0, 1'b0, "R3 top up");
    step(1'b1, 18'h3bb, 1'b1, 1'b0, 1'b0, "R3 rw full");
    while (q.size() > 0) step(1'b0, '0, 1'b1, 1'b0, 1'b0, "R3 drain");
  endtask

  task automatic t_cfg_prst;
    do_reset(1'b0, 1'b0);
    for (int i = 0; i < 6; i++) step(1'b1, DW'(32'h200 + i), 1'b0, 1'b0, 1'b0, "R7 load");
    cfg(1'b0, 6);
    cfg(1'b1, 10);
    step(1'b1, 18'h2ff, 1'b0, 1'b0, 1'b1, "R9 prst");
    for (int i = 0; i < 7; i++) step(1'b1, DW'(32'h210 + i), 1'b0, 1'b0, 1'b0, "R9 kept thresholds");
    for (int i = 0; i < 3; i++) step(1'b0, '0, 1'b1, 1'b0, 1'b0, "R9 kept mode");
  endtask

  task automatic t_rexmit;
    do_reset(1'b0, 1'b1);
    for (int i = 0; i < 5; i++) step(1'b1, DW'(32'h300 + i), 1'b0, 1'b0, 1'b0, "R10 load");
    for (int i = 0; i < 3; i++) step(1'b0, '0, 1'b1, 1'b0, 1'b0, "R10 first pass");
    step(1'b1, 18'h3ff, 1'b1, 1'b1, 1'b0, "R10 rewind");
    for (int i = 0; i < 6; i++) step(1'b0, '0, 1'b1, 1'b0, 1'b0, "R10 replay");
  endtask

  task automatic t_fwft;
    do_reset(1'b1, 1'b1);
    step(1'b1, 18'h055, 1'b0, 1'b0, 1'b0, "R4 first word");
    for (int i = 0; i < 6; i++) step(1'b1, DW'(32'h060 + i), 1'b0, 1'b0, 1'b0, "R4 fill");
    for (int i = 0; i < 3; i++) step(1'b0, '0, 1'b1, 1'b0, 1'b0, "R4 pop");
    step(1'b0, '0, 1'b0, 1'b0, 1'b1, "R9 prst fwft");
    step(1'b1, 18'h0c3, 1'b0, 1'b0, 1'b0, "R9 fwft kept");
    step(1'b0, '0, 1'b1, 1'b0, 1'b0, "R4 last pop");
  endtask

  bit done = 1'b0;

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_fill_drain();
    t_simul();
    t_cfg_prst();
    t_rexmit();
    t_fwft();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule